// File: doc/BRIEF.md
# E4M3 to Half-Precision Widening Converter

This block takes one 8-bit floating-point code in the E4M3 layout (1 sign bit, 4 exponent bits with bias 7, 3 fraction bits) and returns the equal IEEE 754 half-precision value. Every finite E4M3 value fits exactly in half precision, so no rounding takes place. Normal codes are rebiased. Subnormal codes are normalised with a leading-one search. The two NaN codes become a quiet NaN that keeps the input sign.

E4M3 has no infinity. Codes with the top exponent field and a fraction below all-ones are ordinary finite numbers from 256 to 448. Only the all-ones pattern below the sign bit is NaN. The result and its valid flag are registered together and leave the block after a fixed `LATENCY` cycles. The data register loads only when the input is valid.

Top module: `e4m3_to_half`

## Requirements
- R1: A normal code with exponent field e (1 to 15, NaN excluded) and fraction f yields output exponent field e+8, output fraction bits [9:7] equal to f, and output fraction bits [6:0] zero.
- R2: Codes 0x7F and 0xFF yield 0x7E00 and 0xFE00 respectively.
- R3: The output is never a half-precision infinity: output bits [14:10] are all ones only for the NaN codes.
- R4: Codes 0x78 to 0x7E yield 0x5C00 plus (f << 7), which are magnitudes 256 to 448. The same holds for 0xF8 to 0xFE with bit 15 set.
- R5: A subnormal code (exponent field 0, fraction f nonzero) yields the exact value f·2^-9 as a half-precision normal. Its output exponent field is 6, 7 or 8.
- R6: Code 0x00 yields 0x0000 and code 0x80 yields 0x8000.
- R7: Output bit 15 equals input bit 7 for every code.
- R8: out_valid equals in_valid delayed by LATENCY cycles (default 1). out_half carries the result of the code sampled with that in_valid.
- R9: While in_valid is low, the data register keeps its value, so out_half does not change for codes presented without valid.
- R10: While reset is asserted, and until the first valid result, out_valid is 0 and out_half is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input code is valid this cycle |
| in_code | input | 8 | E4M3 code |
| out_valid | output | 1 | out_half is valid |
| out_half | output | 16 | Half-precision result |

## Verification
A fault in the classifier shows up as one class of codes decoding wrongly. For example, the top-exponent codes would come out as infinity, or zero would come out as a subnormal. That class can be seen at the ports one LATENCY period after its first valid code. A fault in the leading-one search shifts the subnormal results by a power of two. A fault in the enable or delay line shows up as a valid pulse in the wrong cycle, or as output data that moves while no valid is present. All 256 codes are streamed back to back, so every class is reached within about 260 cycles of reset release.

// File: rtl/e4h_pkg.sv
package e4h_pkg;
  typedef enum logic [1:0] {
    K_ZERO = 2'd0,
    K_SUB  = 2'd1,
    K_NORM = 2'd2,
    K_NAN  = 2'd3
  } kind_e;
endpackage

// File: rtl/e4h_rst_sync.sv
module e4h_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/e4h_classify.sv
module e4h_classify
  import e4h_pkg::*;
#(
  parameter int EW = 4,
  parameter int MW = 3
) (
  input  logic [EW+MW:0] code,
  output logic           sign,
  output logic [EW-1:0]  exp_f,
  output logic [MW-1:0]  man_f,
  output kind_e          kind
);
  assign sign  = code[EW+MW];
  assign exp_f = code[EW+MW-1:MW];
  assign man_f = code[MW-1:0];

  // Only the all-ones pattern below the sign is NaN; the rest of the
  // top exponent row is finite.
  always_comb begin
    if ((&exp_f) && (&man_f))      kind = K_NAN;
    else if (exp_f == '0 && man_f == '0) kind = K_ZERO;
    else if (exp_f == '0)          kind = K_SUB;
    else                           kind = K_NORM;
  end
endmodule

// File: rtl/e4h_subnorm.sv
module e4h_subnorm #(
  parameter int MW      = 3,
  parameter int OEW     = 5,
  parameter int OMW     = 10,
  parameter int EXP_OFF = 6
) (
  input  logic [MW-1:0]  man,
  output logic [OEW-1:0] exp_o,
  output logic [OMW-1:0] frac_o
);
  localparam int PW = (MW > 1) ? $clog2(MW) : 1;
  localparam int WW = MW + OMW;

  logic [PW-1:0] lead;
  logic [WW-1:0] wide;

  // Leading-one search: the highest set bit wins.
  always_comb begin
    lead = '0;
    for (int i = 0; i < MW; i++) begin
      if (man[i]) lead = PW'(i);
    end
  end

  // Shift the bits below the leading one to the top of the fraction.
  assign wide   = {man, {OMW{1'b0}}} >> lead;
  assign frac_o = wide[OMW-1:0];
  assign exp_o  = OEW'(EXP_OFF) + OEW'(lead);
endmodule

// File: rtl/e4h_assemble.sv
module e4h_assemble
  import e4h_pkg::*;
#(
  parameter int EW     = 4,
  parameter int MW     = 3,
  parameter int OEW    = 5,
  parameter int OMW    = 10,
  parameter int REBIAS = 8
) (
  input  logic           sign,
  input  kind_e          kind,
  input  logic [EW-1:0]  exp_f,
  input  logic [MW-1:0]  man_f,
  input  logic [OEW-1:0] sub_exp,
  input  logic [OMW-1:0] sub_frac,
  output logic [OEW+OMW:0] half
);
  always_comb begin
    unique case (kind)
      K_ZERO: half = {sign, {(OEW+OMW){1'b0}}};
      K_SUB:  half = {sign, sub_exp, sub_frac};
      K_NORM: half = {sign, OEW'(exp_f) + OEW'(REBIAS), man_f, {(OMW-MW){1'b0}}};
      default: half = {sign, {OEW{1'b1}}, 1'b1, {(OMW-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/e4h_pipe.sv
module e4h_pipe #(
  parameter int W     = 16,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  logic         v [DEPTH+1];
  logic [W-1:0] d [DEPTH+1];

  assign v[0] = in_vld;
  assign d[0] = in_dat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] d_nxt;
    logic         load;
    assign load = v[g];
    always_comb d_nxt = load ? d[g] : d[g+1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v[g+1] <= 1'b0;
        d[g+1] <= '0;
      end else begin
        v[g+1] <= v[g];
        d[g+1] <= d_nxt;
      end
    end
  end

  assign out_vld = v[DEPTH];
  assign out_dat = d[DEPTH];
endmodule

// File: rtl/e4m3_to_half.sv
module e4m3_to_half
  import e4h_pkg::*;
#(
  parameter int IN_EXP_W  = 4,
  parameter int IN_MAN_W  = 3,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 10,
  parameter int LATENCY   = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [IN_EXP_W+IN_MAN_W:0]      in_code,
  output logic                            out_valid,
  output logic [OUT_EXP_W+OUT_MAN_W:0]    out_half
);
  localparam int IN_W     = IN_EXP_W + IN_MAN_W + 1;
  localparam int OUT_W    = OUT_EXP_W + OUT_MAN_W + 1;
  localparam int IN_BIAS  = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int REBIAS   = OUT_BIAS - IN_BIAS;
  localparam int SUB_EXP0 = OUT_BIAS + 1 - IN_BIAS - IN_MAN_W;

  logic                 rst_q_n;
  logic                 sign;
  logic [IN_EXP_W-1:0]  exp_f;
  logic [IN_MAN_W-1:0]  man_f;
  kind_e                kind;
  logic [OUT_EXP_W-1:0] sub_exp;
  logic [OUT_MAN_W-1:0] sub_frac;
  logic [OUT_W-1:0]     half_c;

  e4h_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  e4h_classify #(.EW(IN_EXP_W), .MW(IN_MAN_W)) u_cls (
    .code  (in_code),
    .sign  (sign),
    .exp_f (exp_f),
    .man_f (man_f),
    .kind  (kind)
  );

  e4h_subnorm #(
    .MW(IN_MAN_W), .OEW(OUT_EXP_W), .OMW(OUT_MAN_W), .EXP_OFF(SUB_EXP0)
  ) u_sub (
    .man    (man_f),
    .exp_o  (sub_exp),
    .frac_o (sub_frac)
  );

  e4h_assemble #(
    .EW(IN_EXP_W), .MW(IN_MAN_W), .OEW(OUT_EXP_W), .OMW(OUT_MAN_W), .REBIAS(REBIAS)
  ) u_asm (
    .sign     (sign),
    .kind     (kind),
    .exp_f    (exp_f),
    .man_f    (man_f),
    .sub_exp  (sub_exp),
    .sub_frac (sub_frac),
    .half     (half_c)
  );

  e4h_pipe #(.W(OUT_W), .DEPTH(LATENCY)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .in_vld  (in_valid),
    .in_dat  (half_c),
    .out_vld (out_valid),
    .out_dat (out_half)
  );
endmodule

// File: rtl/e4h_chk.sv
module e4h_chk #(
  parameter int IN_EXP_W  = 4,
  parameter int IN_MAN_W  = 3,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 10,
  parameter int LATENCY   = 1
) (
  input logic                         clk,
  input logic                         rst_q_n,
  input logic                         in_valid,
  input logic [IN_EXP_W+IN_MAN_W:0]   in_code,
  input logic                         out_valid,
  input logic [OUT_EXP_W+OUT_MAN_W:0] out_half
);
  localparam int IN_W  = IN_EXP_W + IN_MAN_W + 1;
  localparam int OUT_W = OUT_EXP_W + OUT_MAN_W + 1;
  localparam int TOP_E = ((1 << IN_EXP_W) - 1) + ((1 << (OUT_EXP_W - 1)) - 1)
                         - ((1 << (IN_EXP_W - 1)) - 1);

  logic            dv [LATENCY+1];
  logic [IN_W-1:0] dc [LATENCY+1];
  assign dv[0] = in_valid;
  assign dc[0] = in_code;

  for (genvar g = 0; g < LATENCY; g++) begin : g_dly
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        dv[g+1] <= 1'b0;
        dc[g+1] <= '0;
      end else begin
        dv[g+1] <= dv[g];
        dc[g+1] <= dc[g];
      end
    end
  end

  logic            lv;
  logic [IN_W-1:0] lc;
  assign lv = dv[LATENCY];
  assign lc = dc[LATENCY];

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid == lv);

  // R2
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lv && (&lc[IN_W-2:0])) |->
      out_half == {lc[IN_W-1], {OUT_EXP_W{1'b1}}, 1'b1, {(OUT_MAN_W-1){1'b0}}});

  // R3
  no_inf_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> out_half[OUT_W-2:0] != {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}});

  // R4
  top_row_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lv && (&lc[IN_W-2:IN_MAN_W]) && !(&lc[IN_MAN_W-1:0])) |->
      out_half[OUT_W-2:OUT_MAN_W] == OUT_EXP_W'(TOP_E));

  // R6
  zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lv && lc[IN_W-2:0] == '0) |-> out_half[OUT_W-2:0] == '0);

  // R7
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    lv |-> out_half[OUT_W-1] == lc[IN_W-1]);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !lv |-> $stable(out_half));
endmodule

bind e4m3_to_half e4h_chk #(
  .IN_EXP_W(IN_EXP_W), .IN_MAN_W(IN_MAN_W),
  .OUT_EXP_W(OUT_EXP_W), .OUT_MAN_W(OUT_MAN_W), .LATENCY(LATENCY)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .in_code   (in_code),
  .out_valid (out_valid),
  .out_half  (out_half)
);

// File: tb/sim_e4m3_to_half.sv
module sim_e4m3_to_half;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_code;
  logic        out_valid;
  logic [15:0] out_half;

  int n_cmp = 0;
  int n_bad = 0;

  e4m3_to_half u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .out_valid (out_valid),
    .out_half  (out_half)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic real p2(int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real code_val(logic [7:0] c);
    real m;
    if (c[6:3] == 4'd0) m = real'(c[2:0]) * p2(-9);
    else                m = real'(8 + c[2:0]) * p2(int'(c[6:3]) - 10);
    return c[7] ? -m : m;
  endfunction

  function automatic real half_val(logic [15:0] h);
    real m;
    if (h[14:10] == 5'd0) m = real'(h[9:0]) * p2(-24);
    else                  m = real'(1024 + h[9:0]) * p2(int'(h[14:10]) - 25);
    return h[15] ? -m : m;
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one code, return the registered result one cycle later.
  task automatic apply(logic [7:0] c, output logic [15:0] h);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8 valid", {15'd0, out_valid}, 16'd1);
    h = out_half;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_code = 8'h00;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid in reset", {15'd0, out_valid}, 16'd0);
    chk(out_half == 16'h0000, "R10 data in reset", out_half, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid after release", {15'd0, out_valid}, 16'd0);
    chk(out_half == 16'h0000, "R10 data after release", out_half, 16'h0000);
  endtask

  task automatic t_zero();
    logic [15:0] h;
    apply(8'h00, h); chk(h == 16'h0000, "R6 plus zero", h, 16'h0000);
    apply(8'h80, h); chk(h == 16'h8000, "R6 minus zero", h, 16'h8000);
  endtask

  task automatic t_nan();
    logic [15:0] h;
    apply(8'h7F, h); chk(h == 16'h7E00, "R2 nan pos", h, 16'h7E00);
    apply(8'hFF, h); chk(h == 16'hFE00, "R2 nan neg", h, 16'hFE00);
  endtask

  task automatic t_top();
    logic [15:0] h;
    logic [15:0] e;
    for (int m = 0; m < 7; m++) begin
      for (int s = 0; s < 2; s++) begin
        e = {s[0], 15'h5C00} + 16'(m << 7);
        apply({s[0], 4'hF, m[2:0]}, h);
        chk(h == e, "R4 top exponent finite", h, e);
        chk(h[14:10] != 5'h1F, "R3 no infinity", h, e);
      end
    end
  endtask

  task automatic t_sub();
    logic [15:0] h;
    logic [15:0] e;
    for (int m = 1; m < 8; m++) begin
      apply({1'b0, 4'h0, m[2:0]}, h);
      e = (m == 1) ? 16'h1800 : (m < 4) ? (16'h1C00 | 16'((m & 1) << 9))
                              : (16'h2000 | 16'((m & 3) << 8));
      chk(h == e, "R5 subnormal", h, e);
      chk(h[14:10] >= 5'd6 && h[14:10] <= 5'd8, "R5 exponent range", h, e);
    end
  endtask

  task automatic t_sweep();
    logic [7:0]  prev;
    logic [15:0] e;
    prev = 8'h00;
    for (int i = 0; i <= 256; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(out_valid == 1'b1, "R8 streaming valid", {15'd0, out_valid}, 16'd1);
        chk(out_half[15] == prev[7], "R7 sign", out_half, {prev[7], 15'd0});
        if (prev[6:0] == 7'h7F) begin
          e = {prev[7], 15'h7E00};
          chk(out_half == e, "R2 sweep nan", out_half, e);
        end else begin
          chk(half_val(out_half) == code_val(prev) && out_half[14:10] != 5'h1F,
              "R1 sweep value", out_half, 16'h0000);
          if (prev[6:3] != 4'd0) begin
            e = {prev[7], 5'(prev[6:3] + 4'd8), prev[2:0], 7'd0};
            chk(out_half == e, "R1 normal layout", out_half, e);
          end
        end
      end
      if (i < 256) begin
        in_valid = 1'b1;
        in_code  = 8'(i);
        prev     = 8'(i);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_hold();
    logic [15:0] h;
    apply(8'h40, h);
    chk(h == 16'h4000, "R1 code 40", h, 16'h4000);
    in_code = 8'h11;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 no valid", {15'd0, out_valid}, 16'd0);
      chk(out_half == 16'h4000, "R9 data held", out_half, 16'h4000);
    end
  endtask

  task automatic t_gap();
    bit pat [6] = '{1, 0, 1, 1, 0, 1};
    bit last = 1'b0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k > 0)
        chk(out_valid == last, "R8 valid pattern", {15'd0, out_valid}, {15'd0, last});
      if (k < 6) begin
        in_valid = pat[k];
        in_code  = 8'h38;
        last     = pat[k];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    t_reset();
    t_zero();
    t_nan();
    t_top();
    t_sub();
    t_sweep();
    t_hold();
    t_gap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule